// File: doc/BRIEF.md
# Reset and Start-Up Timer Sequencer

This block keeps a microcontroller core in reset until the supply and the oscillator can be trusted. A power-good level acts as the power-on reset. A brown-out flag and an active-low external clear pin are further reset causes. While any of these is active, the core stays in reset. Once all of them are released, a power-up delay runs first, counted in cycles of a free-running timer clock. In the crystal oscillator modes, an oscillator start-up count follows, counted in rising edges of the oscillator. In RC mode that count is skipped.

The core then leaves reset on the next oscillator rising edge, and a one-cycle strobe tells it to load the reset vector (address 0x000). A brown-out or clear that arrives partway through restarts the whole sequence from the beginning.

The block also keeps two status bits for the core:
- a time-out bit;
- a power-down bit, which tells a clear taken while the core slept apart from one taken while it ran.

All logic runs on the timer clock. The clear, brown-out and oscillator inputs are resynchronised in that clock domain.

Top module: `rst_startup_seq`

## Requirements
- R1: While `pwr_ok` is low, `core_rst` is 1, `vec_load` is 0 and `to_bit` and `pd_bit` are both 1; this takes effect at once, without waiting for a clock edge.
- R2: After every reset cause is released, the power-up delay holds the core in reset for exactly `PWRT_CYCLES` timer clocks before the next phase begins.
- R3: `osc_mode` encodes 00 = LP, 01 = XT, 10 = HS and 11 = RC. In LP, XT and HS, `OST_CYCLES` oscillator rising edges are counted after the delay. In RC mode that count is skipped.
- R4: Once the counts are done, `core_rst` falls one timer clock after the next synchronised oscillator rising edge, and not before.
- R5: A brown-out (`bod_low` = 1) that arrives during the power-up delay returns the block to reset and restarts the delay from zero.
- R6: `mclr_n` low resets the core from any phase, including normal running. When it is released, the full sequence runs again.
- R7: `vec_load` is a single-cycle pulse. It is high exactly in the first cycle in which `core_rst` is 0.
- R8: A clear taken while the core runs with `core_sleep` = 1 sets `pd_bit` to 0. A clear taken while `core_sleep` = 0 leaves `pd_bit` unchanged. `to_bit` is not changed by a clear.
- R9: A synchronised brown-out sets both `to_bit` and `pd_bit` to 1.
- R10: `mclr_n`, `bod_low` and `osc_clk` each pass through a `SYNC_STAGES`-flop synchroniser. The synchroniser resets to the in-reset value, so a pulse of a single timer clock is still seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_tmr | input | 1 | Free-running timer clock; all state is clocked on it |
| pwr_ok | input | 1 | Supply above the power-on level; low acts as an asynchronous power-on reset |
| bod_low | input | 1 | Supply below the brown-out threshold |
| mclr_n | input | 1 | External clear pin, active low |
| osc_clk | input | 1 | Oscillator output, sampled as data |
| osc_mode | input | 2 | Oscillator mode: 00 LP, 01 XT, 10 HS, 11 RC |
| core_sleep | input | 1 | Core is in its sleep state |
| core_rst | output | 1 | Reset to the core, active high |
| vec_load | output | 1 | One-cycle strobe: load the program counter with 0x000 |
| to_bit | output | 1 | Time-out status bit |
| pd_bit | output | 1 | Power-down status bit |

## Verification
The bench goes after a brown-out that lands in the middle of the power-up delay. A design that only paused the counter there, rather than clearing it, would release the core early.

It also runs all four oscillator modes. A sequencer that counted oscillator edges in RC mode, or skipped them in LP, would release the core at the wrong cycle.

Clears are applied both with the core asleep and with it awake. This exposes a power-down bit that ignores `core_sleep`, or a time-out bit that a clear disturbs. One-cycle glitches on the clear pin and a power-good drop during running expose a release that is not aligned to the oscillator, and a strobe that lasts more than one cycle or misses the release cycle.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_HOLD = 3'd0,
    ST_PWRT = 3'd1,
    ST_OST  = 3'd2,
    ST_SYNC = 3'd3,
    ST_RUN  = 3'd4
  } seq_state_e;

  localparam logic [1:0] MODE_LP = 2'b00;
  localparam logic [1:0] MODE_XT = 2'b01;
  localparam logic [1:0] MODE_HS = 2'b10;
  localparam logic [1:0] MODE_RC = 2'b11;

  // Crystal and resonator modes need the oscillator start-up count.
  function automatic logic mode_needs_ost(input logic [1:0] mode);
    return mode != MODE_RC;
  endfunction

  // Width of a counter that runs from 0 to lim-1.
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim);
  endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain[0] <= RST_VAL;
          else         chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain[i] <= RST_VAL;
          else         chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rst_edge_det.sv
module rst_edge_det (
  input  logic clk,
  input  logic arst_n,
  input  logic sig_s,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) prev_q <= 1'b0;
    else         prev_q <= sig_s;
  end

  assign rise = sig_s & ~prev_q;
endmodule

// File: rtl/rst_term_counter.sv
module rst_term_counter
  import rst_seq_pkg::*;
#(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic arst_n,
  input  logic clr,
  input  logic inc,
  output logic done
);
  localparam int unsigned CW = cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] count_q;

  assign done = inc && (count_q == LAST);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)   count_q <= '0;
    else if (clr)  count_q <= '0;
    else if (inc)  count_q <= done ? '0 : count_q + 1'b1;
  end
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       cause,
  input  logic       pwrt_done,
  input  logic       ost_done,
  input  logic       osc_rise,
  input  logic [1:0] osc_mode,
  output seq_state_e state,
  output logic       vld
);
  seq_state_e state_q, state_d;
  logic       vld_q;

  always_comb begin
    state_d = state_q;
    if (cause) begin
      state_d = ST_HOLD;
    end else begin
      unique case (state_q)
        ST_HOLD: state_d = ST_PWRT;
        ST_PWRT: if (pwrt_done) state_d = mode_needs_ost(osc_mode) ? ST_OST : ST_SYNC;
        ST_OST:  if (ost_done)  state_d = ST_SYNC;
        ST_SYNC: if (osc_rise)  state_d = ST_RUN;
        ST_RUN:  state_d = ST_RUN;
        default: state_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_HOLD;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      vld_q   <= (state_q == ST_SYNC) && osc_rise && !cause;
    end
  end

  assign state = state_q;
  assign vld   = vld_q;
endmodule

// File: rtl/rst_startup_seq.sv
module rst_startup_seq
  import rst_seq_pkg::*;
#(
  parameter int unsigned PWRT_CYCLES = 72000,
  parameter int unsigned OST_CYCLES  = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_tmr,
  input  logic       pwr_ok,
  input  logic       bod_low,
  input  logic       mclr_n,
  input  logic       osc_clk,
  input  logic [1:0] osc_mode,
  input  logic       core_sleep,
  output logic       core_rst,
  output logic       vec_load,
  output logic       to_bit,
  output logic       pd_bit
);
  logic       mclr_s, bod_s, osc_s, osc_rise;
  logic       reset_cause, pwrt_done, ost_done;
  seq_state_e seq_state;
  logic       to_q, pd_q;

  rst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mclr (
    .clk(clk_tmr), .arst_n(pwr_ok), .d(mclr_n), .q(mclr_s));
  rst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_bod (
    .clk(clk_tmr), .arst_n(pwr_ok), .d(bod_low), .q(bod_s));
  rst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_osc (
    .clk(clk_tmr), .arst_n(pwr_ok), .d(osc_clk), .q(osc_s));

  rst_edge_det u_osc_edge (
    .clk(clk_tmr), .arst_n(pwr_ok), .sig_s(osc_s), .rise(osc_rise));

  assign reset_cause = bod_s | ~mclr_s;

  rst_term_counter #(.LIMIT(PWRT_CYCLES)) u_pwrt_cnt (
    .clk(clk_tmr), .arst_n(pwr_ok),
    .clr(seq_state != ST_PWRT || reset_cause),
    .inc(seq_state == ST_PWRT),
    .done(pwrt_done));

  rst_term_counter #(.LIMIT(OST_CYCLES)) u_ost_cnt (
    .clk(clk_tmr), .arst_n(pwr_ok),
    .clr(seq_state != ST_OST || reset_cause),
    .inc(seq_state == ST_OST && osc_rise),
    .done(ost_done));

  rst_seq_fsm u_fsm (
    .clk(clk_tmr), .arst_n(pwr_ok), .cause(reset_cause),
    .pwrt_done(pwrt_done), .ost_done(ost_done), .osc_rise(osc_rise),
    .osc_mode(osc_mode), .state(seq_state), .vld(vec_load));

  // Status bits: power-on and brown-out set both; a clear taken in sleep drops PD.
  always_ff @(posedge clk_tmr or negedge pwr_ok) begin
    if (!pwr_ok) begin
      to_q <= 1'b1;
      pd_q <= 1'b1;
    end else if (bod_s) begin
      to_q <= 1'b1;
      pd_q <= 1'b1;
    end else if (seq_state == ST_RUN && !mclr_s && core_sleep) begin
      pd_q <= 1'b0;
    end
  end

  assign core_rst = (seq_state != ST_RUN);
  assign to_bit   = to_q;
  assign pd_bit   = pd_q;
endmodule

// File: rtl/rst_startup_seq_chk.sv
module rst_startup_seq_chk
  import rst_seq_pkg::*;
(
  input logic       clk,
  input logic       arst_n,
  input logic       cause,
  input logic       bod_s,
  input logic       mclr_s,
  input logic       osc_rise,
  input logic       pwrt_done,
  input seq_state_e state,
  input logic [1:0] osc_mode,
  input logic       core_sleep,
  input logic       core_rst,
  input logic       vec_load,
  input logic       to_bit,
  input logic       pd_bit
);
  p_pwrt_in_delay_r2: assert property (@(posedge clk) disable iff (!arst_n)
    pwrt_done |-> state == ST_PWRT);

  p_rc_skips_ost_r3: assert property (@(posedge clk) disable iff (!arst_n)
    (state == ST_PWRT && pwrt_done && !cause && osc_mode == MODE_RC) |=> state == ST_SYNC);

  p_release_on_edge_r4: assert property (@(posedge clk) disable iff (!arst_n)
    (state == ST_SYNC && !osc_rise) |=> core_rst);

  p_bod_restarts_r5: assert property (@(posedge clk) disable iff (!arst_n)
    (state == ST_PWRT && bod_s) |=> state == ST_HOLD);

  p_clear_resets_r6: assert property (@(posedge clk) disable iff (!arst_n)
    !mclr_s |=> core_rst);

  p_strobe_at_release_r7: assert property (@(posedge clk) disable iff (!arst_n)
    vec_load |-> $fell(core_rst));

  p_release_has_strobe_r7: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(core_rst) |-> vec_load);

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!arst_n)
    vec_load |=> !vec_load);

  p_pd_clear_in_sleep_r8: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(pd_bit) |-> ($past(core_sleep) && !$past(mclr_s)));

  p_to_never_drops_r8: assert property (@(posedge clk) disable iff (!arst_n)
    !$fell(to_bit));

  p_bod_sets_status_r9: assert property (@(posedge clk) disable iff (!arst_n)
    bod_s |=> (to_bit && pd_bit));

  p_osc_pulse_r10: assert property (@(posedge clk) disable iff (!arst_n)
    osc_rise |=> !osc_rise);
endmodule

bind rst_startup_seq rst_startup_seq_chk u_chk (
  .clk(clk_tmr), .arst_n(pwr_ok), .cause(reset_cause), .bod_s(bod_s),
  .mclr_s(mclr_s), .osc_rise(osc_rise), .pwrt_done(pwrt_done),
  .state(seq_state), .osc_mode(osc_mode), .core_sleep(core_sleep),
  .core_rst(core_rst), .vec_load(vec_load), .to_bit(to_bit), .pd_bit(pd_bit));

// File: tb/sim_rst_startup_seq.sv
`timescale 1ns/1ps
module sim_rst_startup_seq;
  localparam int PWRT = 20;
  localparam int OST  = 16;
  localparam int SYN  = 2;

  logic clk = 1'b0;
  logic pwr_ok = 1'b0, bod_low = 1'b0, mclr_n = 1'b1, osc_clk = 1'b0;
  logic [1:0] osc_mode = 2'b01;
  logic core_sleep = 1'b0;
  logic core_rst, vec_load, to_bit, pd_bit;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  rst_startup_seq #(.PWRT_CYCLES(PWRT), .OST_CYCLES(OST), .SYNC_STAGES(SYN)) u0 (
    .clk_tmr(clk), .pwr_ok(pwr_ok), .bod_low(bod_low), .mclr_n(mclr_n),
    .osc_clk(osc_clk), .osc_mode(osc_mode), .core_sleep(core_sleep),
    .core_rst(core_rst), .vec_load(vec_load), .to_bit(to_bit), .pd_bit(pd_bit));

  // Behavioural reference: delay lines as queues, phase as integer
  // (0 held, 1 delay, 2 osc count, 3 wait edge, 4 running).
  bit q_mclr[$], q_bod[$], q_osc[$];
  bit m_prev, m_to, m_pd, m_vld;
  int phase, cnt;

  task automatic model_reset();
    q_mclr = {}; q_bod = {}; q_osc = {};
    for (int i = 0; i < SYN; i++) begin
      q_mclr.push_back(1'b0); q_bod.push_back(1'b1); q_osc.push_back(1'b0);
    end
    m_prev = 0; m_to = 1; m_pd = 1; m_vld = 0; phase = 0; cnt = 0;
  endtask

  task automatic model_step();
    bit ms, bs, os, rise, cause;
    ms = q_mclr[SYN-1]; bs = q_bod[SYN-1]; os = q_osc[SYN-1];
    rise  = os && !m_prev;
    cause = bs || !ms;
    if (bs) begin m_to = 1; m_pd = 1; end
    else if (phase == 4 && !ms && core_sleep) m_pd = 0;
    m_vld = (phase == 3) && rise && !cause;
    if (cause) begin phase = 0; cnt = 0; end
    else if (phase == 0) begin phase = 1; cnt = 0; end
    else if (phase == 1) begin
      if (cnt == PWRT - 1) begin phase = (osc_mode == 2'b11) ? 3 : 2; cnt = 0; end
      else cnt++;
    end else if (phase == 2) begin
      if (rise) begin
        if (cnt == OST - 1) begin phase = 3; cnt = 0; end
        else cnt++;
      end
    end else if (phase == 3) begin
      if (rise) phase = 4;
    end
    m_prev = os;
    void'(q_mclr.pop_back()); q_mclr.push_front(mclr_n);
    void'(q_bod.pop_back());  q_bod.push_front(bod_low);
    void'(q_osc.pop_back());  q_osc.push_front(osc_clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!pwr_ok) model_reset();
    else model_step();
    #1;
    check({core_rst, vec_load, to_bit, pd_bit} == {(phase != 4), m_vld, m_to, m_pd},
          cur_req, "rst/vld/to/pd",
          {core_rst, vec_load, to_bit, pd_bit}, {(phase != 4), m_vld, m_to, m_pd});
    cycles++;
    if (cycles > 150000 && !done_flag) begin
      check(0, cur_req, "watchdog", cycles, 150000);
      finish_run();
    end
  end

  // Oscillator: period of six timer clocks.
  initial forever begin
    repeat (3) @(negedge clk);
    osc_clk = ~osc_clk;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_to_release(input int limit);
    for (int i = 0; i < limit && core_rst; i++) @(negedge clk);
    wait_cyc(3);
  endtask

  initial begin
    // R1: reset state while power is not good
    wait_cyc(2);
    check(core_rst == 1 && vec_load == 0 && to_bit == 1 && pd_bit == 1, "R1",
          "reset state", {core_rst, vec_load, to_bit, pd_bit}, 4'b1011);
    pwr_ok = 1'b1;

    // R2 R3 R4 R7: XT full sequence
    cur_req = "R2 R3 R4 R7 XT";
    run_to_release(400);
    check(core_rst == 0, "R2", "released in XT", core_rst, 0);

    // R6 R8: clear while awake keeps PD
    cur_req = "R6 R8 awake";
    core_sleep = 0; mclr_n = 0; wait_cyc(4); mclr_n = 1;
    run_to_release(400);
    check(pd_bit == 1, "R8", "pd after awake clear", pd_bit, 1);

    // R8: clear during sleep drops PD, TO untouched
    cur_req = "R8 sleep";
    core_sleep = 1; mclr_n = 0; wait_cyc(4); core_sleep = 0; mclr_n = 1;
    run_to_release(400);
    check(pd_bit == 0 && to_bit == 1, "R8", "pd/to after sleep clear",
          {to_bit, pd_bit}, 2'b10);

    // R5 R9: brown-out during the delay restarts it and sets status
    cur_req = "R5 R9";
    mclr_n = 0; wait_cyc(2); mclr_n = 1;
    wait_cyc(SYN + 10);
    bod_low = 1; wait_cyc(2); bod_low = 0;
    run_to_release(400);
    check(pd_bit == 1 && to_bit == 1, "R9", "status after brown-out",
          {to_bit, pd_bit}, 2'b11);

    // R3: RC mode skips the oscillator count
    cur_req = "R3 RC";
    osc_mode = 2'b11; mclr_n = 0; wait_cyc(3); mclr_n = 1;
    run_to_release(400);
    // R3: LP and HS modes count edges
    cur_req = "R3 LP";
    osc_mode = 2'b00; mclr_n = 0; wait_cyc(3); mclr_n = 1;
    run_to_release(400);
    cur_req = "R3 HS";
    osc_mode = 2'b10; mclr_n = 0; wait_cyc(3); mclr_n = 1;
    run_to_release(400);

    // R10: one-cycle glitch on the clear pin still resets
    cur_req = "R10 glitch";
    mclr_n = 0; wait_cyc(1); mclr_n = 1;
    wait_cyc(SYN + 1);
    check(core_rst == 1, "R10", "glitch held core", core_rst, 1);
    run_to_release(400);

    // R5: brown-out while running, then late in the delay
    cur_req = "R5 late";
    bod_low = 1; wait_cyc(3); bod_low = 0;
    wait_cyc(SYN + PWRT - 2);
    bod_low = 1; wait_cyc(1); bod_low = 0;
    run_to_release(400);

    // R1: power drop while running acts at once
    cur_req = "R1 drop";
    @(negedge clk); pwr_ok = 0; #1;
    check(core_rst == 1 && to_bit == 1 && pd_bit == 1 && vec_load == 0, "R1",
          "async power drop", {core_rst, vec_load, to_bit, pd_bit}, 4'b1011);
    wait_cyc(3); pwr_ok = 1;
    cur_req = "R1 R2 restart";
    osc_mode = 2'b01;
    run_to_release(400);
    check(core_rst == 0, "R2", "released after power drop", core_rst, 0);

    done_flag = 1;
    wait_cyc(2);
    finish_run();
  end
endmodule